// File: doc/BRIEF.md
# Sliced ELLPACK Sparse Matrix-Vector Engine

This block multiplies a square sparse matrix by a dense vector, y = A·x, where the matrix arrives in sliced ELLPACK form. Rows are grouped into slices of `SLICE_H` consecutive rows. Each slice is padded only to the length of its own longest row. Inside a slice, the value and column arrays are laid out slot by slot: slot 0 of every row in the slice comes first, then slot 1 of every row, and so on. A cumulative boundary table marks where each slice ends in those arrays.

A run starts with a one-cycle `start` pulse. The engine then takes the whole problem over a 32-bit AXI4-Stream input and holds it in local storage. After that it walks the slices in order and emits one 32-bit result per row on an AXI4-Stream output, which honours backpressure. When the last row has been accepted downstream, `done` pulses for one cycle. A slice whose boundary data is inconsistent sets a sticky error flag and yields zero for its rows. The other slices are not affected.

Top module: `sell_spmv_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `m_tvalid` and `s_tready` are all low.
- R2: A run takes its input words in this order. The first word is the row count N, and the slice count is ceil(N/SLICE_H). Next come that many cumulative boundaries, then E values, where E is the last boundary. Then come E column indices, and last N words of x. `s_tready` is high only while these words are being taken.
- R3: Slice s covers rows s·SLICE_H onward. It holds min(SLICE_H, N − s·SLICE_H) rows, so the last slice may be shorter than the others.
- R4: The slot width of a slice is (its boundary − the previous boundary, with 0 before slice 0) divided by its row count. The entry for row i, slot j sits at previous boundary + j·rows + i.
- R5: An entry whose column index is 0xFFFFFFFF is padding. It contributes nothing, whatever its value.
- R6: Each result is the sum of value·x[column] over the row's non-padding entries. Values are signed two's complement, and the result keeps the low 32 bits.
- R7: Exactly N results are emitted, in global row order, slice after slice.
- R8: While `m_tvalid` is high and `m_tready` is low, `m_tvalid` stays high and `m_tdata` holds its value.
- R9: `done` is high for exactly one cycle: the cycle after the final result is accepted. `busy` falls in the next cycle.
- R10: A slice is rejected when its entry count is not a multiple of its row count, or when its boundary is below the previous one. A rejected slice sets `err`, which stays high until the next accepted `start`. Its rows produce 0, and the other slices are computed normally.
- R11: A `start` pulse while `busy` is high is ignored, and the run in progress is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the engine is idle |
| busy | output | 1 | High from an accepted start until the run ends |
| done | output | 1 | One-cycle pulse after the final result is accepted |
| err | output | 1 | Sticky flag: a slice was rejected in this run |
| s_tdata | input | 32 | Input stream data word |
| s_tvalid | input | 1 | Input stream valid |
| s_tready | output | 1 | Input stream ready (loading phase only) |
| m_tdata | output | 32 | Result for the current row |
| m_tvalid | output | 1 | Result valid |
| m_tready | input | 1 | Downstream ready |

## Verification
A wrong base, row count or slot width inside a slice corrupts the address sequence. That shows up as a wrong value on the first emitted row of the affected slice, and every later row of that slice is wrong as well. A slipped loading counter misplaces every word after the slip, so the results of the first slice that uses the misplaced data already disagree. A wrong row or slice counter shows up as too few or too many results, or as a `done` pulse that is missing or arrives in the wrong cycle. The sweep covers every row count up to the maximum, with a slice height that does not divide most of them, so the short final slice is exercised.

// File: rtl/sell_pkg.sv
package sell_pkg;
    typedef logic [31:0] word_t;

    typedef enum logic [3:0] {
        S_IDLE, S_HDR, S_OFF, S_VAL, S_COL, S_X,
        S_SLICE, S_DIV, S_ROW, S_EMIT, S_FIN
    } phase_e;

    typedef struct packed {
        phase_e ph;
        word_t  idx;    // load index
        word_t  n;      // row count
        word_t  nsl;    // slice count
        word_t  nent;   // total entries
        word_t  s;      // current slice
        word_t  rbase;  // first row of slice
        word_t  base;   // previous boundary
        word_t  endo;   // this slice's boundary
        word_t  rows;   // rows in slice
        word_t  rem;    // division remainder
        word_t  width;  // slots in slice
        word_t  j;      // slot
        word_t  r;      // row within slice
        word_t  addr;   // entry address
        word_t  acc;
        logic   bad;
        logic   err;
    } eng_t;

    localparam word_t PAD_COL = 32'hFFFF_FFFF;
endpackage

// File: rtl/sell_regfile.sv
module sell_regfile
    import sell_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic  clk,
    input  logic  we,
    input  word_t waddr,
    input  word_t wdata,
    input  word_t raddr,
    output word_t rdata
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr < word_t'(DEPTH)))
            mem[waddr[AW-1:0]] <= wdata;
    end

    assign rdata = (raddr < word_t'(DEPTH)) ? mem[raddr[AW-1:0]] : '0;
endmodule

// File: rtl/sell_slot_mac.sv
module sell_slot_mac
    import sell_pkg::*;
(
    input  word_t acc_in,
    input  word_t val,
    input  word_t xv,
    input  word_t col,
    output word_t acc_out
);
    word_t prod;

    always_comb begin
        prod    = val * xv;
        acc_out = (col == PAD_COL) ? acc_in : acc_in + prod;
    end
endmodule

// File: rtl/sell_spmv_engine.sv
module sell_spmv_engine
    import sell_pkg::*;
#(
    parameter int SLICE_H  = 3,
    parameter int MAX_ROWS = 8,
    parameter int MAX_ENT  = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        busy,
    output logic        done,
    output logic        err,
    input  logic [31:0] s_tdata,
    input  logic        s_tvalid,
    output logic        s_tready,
    output logic [31:0] m_tdata,
    output logic        m_tvalid,
    input  logic        m_tready
);
    localparam int    MAX_SL = (MAX_ROWS + SLICE_H - 1) / SLICE_H;
    localparam word_t H_W    = word_t'(SLICE_H);

    eng_t  st_q, st_d;
    logic  in_hs;
    word_t off_rd, val_rd, col_rd, x_rd, mac_out;
    word_t left_rows;

    // storage for the four loaded arrays
    sell_regfile #(.DEPTH(MAX_SL)) u_off (
        .clk(clk), .we(in_hs && st_q.ph == S_OFF), .waddr(st_q.idx),
        .wdata(s_tdata), .raddr(st_q.s), .rdata(off_rd));
    sell_regfile #(.DEPTH(MAX_ENT)) u_val (
        .clk(clk), .we(in_hs && st_q.ph == S_VAL), .waddr(st_q.idx),
        .wdata(s_tdata), .raddr(st_q.addr), .rdata(val_rd));
    sell_regfile #(.DEPTH(MAX_ENT)) u_col (
        .clk(clk), .we(in_hs && st_q.ph == S_COL), .waddr(st_q.idx),
        .wdata(s_tdata), .raddr(st_q.addr), .rdata(col_rd));
    sell_regfile #(.DEPTH(MAX_ROWS)) u_x (
        .clk(clk), .we(in_hs && st_q.ph == S_X), .waddr(st_q.idx),
        .wdata(s_tdata), .raddr(col_rd), .rdata(x_rd));

    sell_slot_mac u_mac (
        .acc_in(st_q.acc), .val(val_rd), .xv(x_rd), .col(col_rd),
        .acc_out(mac_out));

    always_comb begin
        s_tready = (st_q.ph == S_HDR) || (st_q.ph == S_OFF) || (st_q.ph == S_VAL) ||
                   (st_q.ph == S_COL) || (st_q.ph == S_X);
        in_hs    = s_tvalid && s_tready;
        m_tvalid = (st_q.ph == S_EMIT);
        m_tdata  = st_q.acc;
        busy     = (st_q.ph != S_IDLE);
        done     = (st_q.ph == S_FIN);
        err      = st_q.err;
        left_rows = st_q.n - st_q.rbase;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            S_IDLE: if (start) begin
                st_d.ph  = S_HDR;
                st_d.err = 1'b0;
            end
            S_HDR: if (in_hs) begin
                st_d.n   = s_tdata;
                st_d.nsl = (s_tdata + H_W - 32'd1) / H_W;
                st_d.idx = '0;
                st_d.ph  = (s_tdata == '0) ? S_FIN : S_OFF;
            end
            S_OFF: if (in_hs) begin
                if (st_q.idx == st_q.nsl - 32'd1) begin
                    st_d.nent = s_tdata;
                    st_d.idx  = '0;
                    st_d.ph   = (s_tdata == '0) ? S_X : S_VAL;
                end else begin
                    st_d.idx = st_q.idx + 32'd1;
                end
            end
            S_VAL: if (in_hs) begin
                if (st_q.idx == st_q.nent - 32'd1) begin
                    st_d.idx = '0;
                    st_d.ph  = S_COL;
                end else begin
                    st_d.idx = st_q.idx + 32'd1;
                end
            end
            S_COL: if (in_hs) begin
                if (st_q.idx == st_q.nent - 32'd1) begin
                    st_d.idx = '0;
                    st_d.ph  = S_X;
                end else begin
                    st_d.idx = st_q.idx + 32'd1;
                end
            end
            S_X: if (in_hs) begin
                if (st_q.idx == st_q.n - 32'd1) begin
                    st_d.s     = '0;
                    st_d.rbase = '0;
                    st_d.base  = '0;
                    st_d.ph    = S_SLICE;
                end else begin
                    st_d.idx = st_q.idx + 32'd1;
                end
            end
            S_SLICE: begin
                st_d.rows  = (left_rows < H_W) ? left_rows : H_W;
                st_d.endo  = off_rd;
                st_d.width = '0;
                if (off_rd < st_q.base) begin
                    st_d.bad = 1'b1;
                    st_d.rem = '0;
                end else begin
                    st_d.bad = 1'b0;
                    st_d.rem = off_rd - st_q.base;
                end
                st_d.ph = S_DIV;
            end
            S_DIV: begin
                if (!st_q.bad && st_q.rem >= st_q.rows) begin
                    st_d.rem   = st_q.rem - st_q.rows;
                    st_d.width = st_q.width + 32'd1;
                end else begin
                    if (st_q.bad || st_q.rem != '0) begin
                        st_d.bad = 1'b1;
                        st_d.err = 1'b1;
                    end
                    st_d.r    = '0;
                    st_d.j    = '0;
                    st_d.acc  = '0;
                    st_d.addr = st_q.base;
                    st_d.ph   = S_ROW;
                end
            end
            S_ROW: begin
                if (st_q.bad || st_q.j == st_q.width) begin
                    st_d.ph = S_EMIT;
                end else begin
                    st_d.acc  = mac_out;
                    st_d.j    = st_q.j + 32'd1;
                    st_d.addr = st_q.addr + st_q.rows;
                end
            end
            S_EMIT: if (m_tready) begin
                if (st_q.r == st_q.rows - 32'd1) begin
                    if (st_q.s == st_q.nsl - 32'd1) begin
                        st_d.ph = S_FIN;
                    end else begin
                        st_d.s     = st_q.s + 32'd1;
                        st_d.rbase = st_q.rbase + H_W;
                        st_d.base  = st_q.endo;
                        st_d.ph    = S_SLICE;
                    end
                end else begin
                    st_d.r    = st_q.r + 32'd1;
                    st_d.j    = '0;
                    st_d.acc  = '0;
                    st_d.addr = st_q.base + st_q.r + 32'd1;
                    st_d.ph   = S_ROW;
                end
            end
            S_FIN: st_d.ph = S_IDLE;
            default: st_d.ph = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!s_tready && !m_tvalid));

    // R10
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (busy && !s_tready));
endmodule

// File: tb/sim_sell_spmv_engine.sv
module sim_sell_spmv_engine;
    localparam int CLK_PERIOD = 10;
    localparam int H    = 3;
    localparam int MAXR = 8;
    localparam int MAXE = 64;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start = 0;
    logic        busy, done, err;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 0;
    logic        s_tready;
    logic [31:0] m_tdata;
    logic        m_tvalid;
    logic        m_tready = 0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    int A  [MAXR][MAXR];
    bit Am [MAXR][MAXR];
    int xv [MAXR];
    int yexp [MAXR];
    int words [256];
    int nwords;
    int vals [80];
    int cols [80];
    int offs [4];

    sell_spmv_engine #(.SLICE_H(H), .MAX_ROWS(MAXR), .MAX_ENT(MAXE)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .err(err), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(bit ok, string tag, int got, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, expv);
        end
    endtask

    // Builds matrix, sliced form (R3, R4, padding per R5) and expected results
    task automatic build(int n, int seed, bit bad, bit empty);
        int e, nsl;
        for (int i = 0; i < MAXR; i++) begin
            xv[i] = ((i * 5 + seed) % 11) - 5;
            for (int c = 0; c < MAXR; c++) begin
                Am[i][c] = !empty && ((((i * 7 + c * 3 + seed) % 5) == 0) ||
                                      (i == c && (seed % 2) == 0));
                A[i][c]  = ((i + 2 * c + seed) % 9) - 4;
            end
        end
        nsl = (n + H - 1) / H;
        e = 0;
        for (int s = 0; s < nsl; s++) begin
            int rows, w;
            rows = (n - s * H < H) ? n - s * H : H;
            w = 0;
            for (int i = 0; i < rows; i++) begin
                int cnt;
                cnt = 0;
                for (int c = 0; c < n; c++) if (Am[s*H+i][c]) cnt++;
                if (cnt > w) w = cnt;
            end
            for (int j = 0; j < w; j++)
                for (int i = 0; i < rows; i++) begin
                    int k, cfound;
                    k = 0; cfound = -1;
                    for (int c = 0; c < n; c++)
                        if (Am[s*H+i][c]) begin
                            if (k == j) cfound = c;
                            k++;
                        end
                    if (cfound >= 0) begin
                        vals[e] = A[s*H+i][cfound]; cols[e] = cfound;
                    end else begin
                        vals[e] = 99; cols[e] = -1;
                    end
                    e++;
                end
            if (bad && s == 0) begin
                vals[e] = 50; cols[e] = 0; e++;
            end
            offs[s] = e;
        end
        nwords = 0;
        words[nwords++] = n;
        for (int s = 0; s < nsl; s++) words[nwords++] = offs[s];
        for (int k = 0; k < e; k++) words[nwords++] = vals[k];
        for (int k = 0; k < e; k++) words[nwords++] = cols[k];
        for (int k = 0; k < n; k++) words[nwords++] = xv[k];
        for (int i = 0; i < n; i++) begin
            int sum;
            sum = 0;
            for (int c = 0; c < n; c++) if (Am[i][c]) sum += A[i][c] * xv[c];
            yexp[i] = (bad && i < H) ? 0 : sum;
        end
    endtask

    task automatic send_all(bit gap, bit poke);
        int k, cyc;
        k = 0; cyc = 0;
        while (k < nwords) begin
            @(negedge clk);
            start = (poke && cyc == 4);
            if (gap && (cyc % 3) == 1) begin
                s_tvalid = 0;
            end else begin
                s_tvalid = 1;
                s_tdata  = words[k];
                if (s_tready) k++;
            end
            cyc++;
        end
        @(negedge clk);
        s_tvalid = 0;
        start = 0;
    endtask

    task automatic collect(int n, int rpat, bit bad, string tag);
        int got, cyc, held;
        bit hold;
        got = 0; cyc = 0; hold = 0; held = 0;
        while (got < n) begin
            @(negedge clk);
            if (hold) begin
                check(m_tvalid && m_tdata == held, "R8 held data", int'(m_tdata), held);
                hold = 0;
            end
            m_tready = (rpat == 0) || ((cyc % (rpat + 1)) != 0);
            if (m_tvalid && m_tready) begin
                check(int'(m_tdata) == yexp[got], tag, int'(m_tdata), yexp[got]);
                got++;
            end else if (m_tvalid) begin
                hold = 1; held = int'(m_tdata);
            end
            cyc++;
        end
        @(negedge clk);
        m_tready = 0;
        check(done == 1'b1, "R9 done after last row", int'(done), 1);
        check(m_tvalid == 1'b0, "R7 no extra result", int'(m_tvalid), 0);
        check(err == bad, "R10 error flag", int'(err), int'(bad));
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R9 single pulse, idle", int'(done) + int'(busy), 0);
        check(s_tready == 1'b0, "R2 ready low when idle", int'(s_tready), 0);
    endtask

    task automatic run_case(int n, int seed, bit gap, int rpat, bit bad, bit empty,
                            bit poke, string tag);
        build(n, seed, bad, empty);
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        fork
            send_all(gap, poke);
            collect(n, rpat, bad, tag);
        join
    endtask

    initial begin
        #(CLK_PERIOD * 2 + 3);
        // R1 reset state
        check(!busy && !done && !err && !m_tvalid && !s_tready, "R1 reset outputs",
              int'(busy) + int'(done) + int'(err) + int'(m_tvalid) + int'(s_tready), 0);
        rst_n = 1;
        // sweep every row count; H=3 leaves a short last slice for most (R3)
        for (int n = 1; n <= MAXR; n++) begin
            run_case(n, n, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R3/R4/R5/R6/R7 row value");
            run_case(n, n + 3, 1'b1, 2, 1'b0, 1'b0, 1'b0, "R4/R6/R8 row value with stalls");
        end
        // all-empty matrix: every slice has width 0
        run_case(5, 2, 1'b0, 1, 1'b0, 1'b1, 1'b0, "R4 empty slices");
        // rejected first slice (R10)
        run_case(7, 1, 1'b0, 0, 1'b1, 1'b0, 1'b0, "R10 rejected slice rows");
        run_case(4, 6, 1'b1, 1, 1'b1, 1'b0, 1'b0, "R10 rejected slice rows");
        // start pulse mid-run must be ignored (R11); err cleared by new start
        run_case(8, 4, 1'b1, 0, 1'b0, 1'b0, 1'b1, "R11 start ignored while busy");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule